// File: doc/BRIEF.md
# Virtual-Channel Slot Allocation Table with Staged Commit

This block keeps the time-slot allocation table of a multi-stream display link receiver. Each of the 64 link time slots carries a 4-bit payload ID, or 0 when the slot is free. Software fills a staging copy of the table and a stream-control word through a small write port. The staging copy reaches the live table in one of two ways. A one-cycle force pulse copies it at once. A held request arms a deferred copy that happens on the next allocation-change trigger pulse coming from the link layer.

After a deferred copy, an acknowledge flag in the status word rises and stays high while the request is held. Dropping the request clears the flag and re-arms the mechanism for the next update. A combinational lookup port takes a slot number and reads the live table. It returns the slot's payload ID and the index of the stream whose configured ID matches it, together with a valid flag.

Top module: `vc_slot_table`

## Requirements
- R1: After reset the control word, the status word, all eight staging registers and the live table are zero, and lookup returns valid low for every slot.
- R2: A write to address 8 loads the control word. Bit 0 selects framing: 1 is multi-stream and 0 is single-stream. Stream s (0 to 3) holds its 4-bit payload ID in bits 4+4s+3 down to 4+4s. Bits 3:1 and 31:20 always read 0. The control word is read back at address 8 and appears on `ctrl_word`.
- R3: Writes to addresses 0 to 7 load staging register k, and read back at the same address. Slot n is held in register n/8 at bits 4*(n%8)+3 down to 4*(n%8). Staging writes do not change the live table.
- R4: A `upd_force` pulse copies the staging table, as it stood before that clock edge, into the live table at that edge.
- R5: When `upd_req` is high and `act_trig` pulses, the staging table is copied at that edge. Status bit 30 becomes 1 at the same edge. The status word is read at address 9 and appears on `status_word`.
- R6: An `act_trig` pulse with `upd_req` low and no force leaves the live table and the status unchanged.
- R7: While the acknowledge bit is set, further triggers leave the live table unchanged. A new deferred copy needs `upd_req` to drop and rise again.
- R8: The acknowledge bit is 0 from the first clock edge at which `upd_req` is sampled low.
- R9: Force together with a trigger under an armed request performs a single copy and still sets the acknowledge bit.
- R10: Lookup returns the live slot entry on `lk_id`. `lk_stream` is the lowest stream index whose control-word ID equals that entry. `lk_valid` is low when the entry is 0, when no stream matches, or when single-stream framing is selected.
- R11: Writes to addresses 9 to 15 change neither the staging table nor the control word, and reads there return 0 except the status word at address 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 32 | Combinational read data |
| upd_force | input | 1 | One-cycle immediate copy command |
| upd_req | input | 1 | Level request arming a deferred copy |
| act_trig | input | 1 | One-cycle allocation-change trigger |
| ctrl_word | output | 32 | Current control word |
| status_word | output | 32 | Status word, acknowledge in bit 30 |
| lk_slot | input | 6 | Slot number to look up |
| lk_stream | output | 2 | Matching stream index |
| lk_valid | output | 1 | Lookup result valid |
| lk_id | output | 4 | Live payload ID of the slot |

## Verification
The force copy and the trigger-driven deferred copy can land on the same edge. A staging write can also coincide with either copy, in which case the copy must take the old staging contents. The bench provokes these collisions with directed cases and with random streams of force pulses, trigger pulses, request toggles and writes that often share a cycle. After every cycle a reference model of the single-copy rule and the acknowledge level judges the result. It sweeps all 64 slots through the lookup port and compares them with its own live table.

// File: rtl/ptab_pkg.sv
`timescale 1ns/1ps
package ptab_pkg;
  localparam int PT_CTRL_ADDR = 8;
  localparam int PT_STAT_ADDR = 9;
  localparam int PT_ACK_BIT   = 30;
  localparam int PT_MODE_BIT  = 0;
  localparam int PT_ID_LSB    = 4;

  typedef enum logic [1:0] {SEL_TABLE, SEL_CTRL, SEL_STAT, SEL_NONE} sel_e;

  // address decode shared by write and read paths
  function automatic sel_e pt_decode(int addr, int nregs);
    if (addr < nregs)             return SEL_TABLE;
    else if (addr == PT_CTRL_ADDR) return SEL_CTRL;
    else if (addr == PT_STAT_ADDR) return SEL_STAT;
    else                           return SEL_NONE;
  endfunction
endpackage

// File: rtl/ptab_regs.sv
`timescale 1ns/1ps
module ptab_regs import ptab_pkg::*; #(
  parameter int NREGS   = 8,
  parameter int REG_W   = 32,
  parameter int ADDR_W  = 4,
  parameter int NSTREAM = 4,
  parameter int ENTRY_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [REG_W-1:0]       wr_data,
  output logic [NREGS*REG_W-1:0] pend_flat,
  output logic [REG_W-1:0]       ctrl_q
);
  function automatic logic [REG_W-1:0] keep_mask();
    logic [REG_W-1:0] m;
    for (int i = 0; i < REG_W; i++)
      m[i] = (i == PT_MODE_BIT) || (i >= PT_ID_LSB && i < PT_ID_LSB + NSTREAM*ENTRY_W);
    return m;
  endfunction
  localparam logic [REG_W-1:0] KEEP = keep_mask();

  logic [NREGS-1:0][REG_W-1:0] pend_q;
  sel_e wsel;
  assign wsel = pt_decode(int'(wr_addr), NREGS);

  for (genvar k = 0; k < NREGS; k++) begin : g_pend
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q[k] <= '0;
      else if (wr_en && wsel == SEL_TABLE && int'(wr_addr) == k) pend_q[k] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (wr_en && wsel == SEL_CTRL) ctrl_q <= wr_data & KEEP;
  end

  assign pend_flat = pend_q;

  // R11: writes outside the table and control addresses touch nothing
  assert_stray_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wsel == SEL_STAT || wsel == SEL_NONE)) |=> ($stable(pend_q) && $stable(ctrl_q)));
endmodule

// File: rtl/ptab_commit.sv
`timescale 1ns/1ps
module ptab_commit (
  input  logic clk,
  input  logic rst_n,
  input  logic upd_force,
  input  logic upd_req,
  input  logic act_trig,
  output logic defer_hit,
  output logic copy_now,
  output logic ack
);
  logic done_q;

  assign defer_hit = upd_req && !done_q && act_trig;
  assign copy_now  = upd_force || defer_hit;
  assign ack       = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         done_q <= 1'b0;
    else if (!upd_req)  done_q <= 1'b0;
    else if (defer_hit) done_q <= 1'b1;
  end

  // R8: dropping the request clears the acknowledge
  assert_ack_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_req |=> !ack);
  // R5: a deferred commit raises the acknowledge
  assert_ack_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (act_trig && upd_req && !ack) |=> ack);
endmodule

// File: rtl/ptab_active.sv
`timescale 1ns/1ps
module ptab_active #(
  parameter int TAB_W = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             copy_now,
  input  logic [TAB_W-1:0] pend_flat,
  output logic [TAB_W-1:0] act_flat
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        act_flat <= '0;
    else if (copy_now) act_flat <= pend_flat;
  end

  // R4: a copy takes the staging contents seen before the edge
  assert_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    copy_now |=> act_flat == $past(pend_flat));
  // R6: without a copy the live table holds
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !copy_now |=> $stable(act_flat));
endmodule

// File: rtl/ptab_lookup.sv
`timescale 1ns/1ps
module ptab_lookup #(
  parameter int SLOTS   = 64,
  parameter int ENTRY_W = 4,
  parameter int NSTREAM = 4,
  parameter int REG_W   = 32,
  parameter int MODE_BIT = 0,
  parameter int ID_LSB  = 4,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int IDX_W  = $clog2(NSTREAM)
) (
  input  logic [SLOTS*ENTRY_W-1:0] act_flat,
  input  logic [REG_W-1:0]         ctrl,
  input  logic [SLOT_W-1:0]        slot,
  output logic [ENTRY_W-1:0]       id,
  output logic [IDX_W-1:0]         stream,
  output logic                     valid
);
  function automatic logic [IDX_W:0] first_hit(logic [NSTREAM-1:0] m);
    logic [IDX_W:0] r;
    r = '0;
    for (int i = NSTREAM-1; i >= 0; i--)
      if (m[i]) r = {1'b1, IDX_W'(i)};
    return r;
  endfunction

  logic [NSTREAM-1:0] match;
  logic [IDX_W:0]     hit;

  assign id = act_flat[int'(slot)*ENTRY_W +: ENTRY_W];

  for (genvar s = 0; s < NSTREAM; s++) begin : g_match
    assign match[s] = (id != '0) && (id == ctrl[ID_LSB + s*ENTRY_W +: ENTRY_W]);
  end

  assign hit    = first_hit(match);
  assign stream = hit[IDX_W-1:0];
  assign valid  = hit[IDX_W] && ctrl[MODE_BIT];
endmodule

// File: rtl/vc_slot_table.sv
`timescale 1ns/1ps
module vc_slot_table import ptab_pkg::*; #(
  parameter int SLOTS   = 64,
  parameter int ENTRY_W = 4,
  parameter int NSTREAM = 4,
  parameter int REG_W   = 32,
  parameter int ADDR_W  = 4,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int IDX_W  = $clog2(NSTREAM)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [REG_W-1:0]   wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [REG_W-1:0]   rd_data,
  input  logic               upd_force,
  input  logic               upd_req,
  input  logic               act_trig,
  output logic [REG_W-1:0]   ctrl_word,
  output logic [REG_W-1:0]   status_word,
  input  logic [SLOT_W-1:0]  lk_slot,
  output logic [IDX_W-1:0]   lk_stream,
  output logic               lk_valid,
  output logic [ENTRY_W-1:0] lk_id
);
  localparam int PER_REG = REG_W / ENTRY_W;
  localparam int NREGS   = SLOTS / PER_REG;
  localparam int TAB_W   = SLOTS * ENTRY_W;

  logic [TAB_W-1:0] pend_flat;
  logic [TAB_W-1:0] act_flat;
  logic [REG_W-1:0] ctrl_q;
  logic             defer_hit, copy_now, ack;
  sel_e             rsel;

  ptab_regs #(.NREGS(NREGS), .REG_W(REG_W), .ADDR_W(ADDR_W),
              .NSTREAM(NSTREAM), .ENTRY_W(ENTRY_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pend_flat(pend_flat), .ctrl_q(ctrl_q));

  ptab_commit u_commit (
    .clk(clk), .rst_n(rst_n), .upd_force(upd_force), .upd_req(upd_req),
    .act_trig(act_trig), .defer_hit(defer_hit), .copy_now(copy_now), .ack(ack));

  ptab_active #(.TAB_W(TAB_W)) u_active (
    .clk(clk), .rst_n(rst_n), .copy_now(copy_now),
    .pend_flat(pend_flat), .act_flat(act_flat));

  ptab_lookup #(.SLOTS(SLOTS), .ENTRY_W(ENTRY_W), .NSTREAM(NSTREAM), .REG_W(REG_W),
                .MODE_BIT(PT_MODE_BIT), .ID_LSB(PT_ID_LSB)) u_lookup (
    .act_flat(act_flat), .ctrl(ctrl_q), .slot(lk_slot),
    .id(lk_id), .stream(lk_stream), .valid(lk_valid));

  always_comb begin
    status_word = '0;
    status_word[PT_ACK_BIT] = ack;
  end

  assign ctrl_word = ctrl_q;
  assign rsel = pt_decode(int'(rd_addr), NREGS);

  always_comb begin
    case (rsel)
      SEL_TABLE: rd_data = pend_flat[int'(rd_addr)*REG_W +: REG_W];
      SEL_CTRL:  rd_data = ctrl_q;
      SEL_STAT:  rd_data = status_word;
      default:   rd_data = '0;
    endcase
  end

  // R7: a trigger while acknowledged and not forced leaves the live table alone
  assert_one_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (act_trig && ack && upd_req && !upd_force) |=> $stable(act_flat));
  // R9: force and armed trigger together still acknowledge with the staged table
  assert_force_trig_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_force && act_trig && upd_req && !ack) |=> (ack && act_flat == $past(pend_flat)));
  // R10: a valid lookup needs multi-stream framing and an allocated entry
  assert_lookup_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> (ctrl_q[PT_MODE_BIT] && lk_id != '0));
  // R5: the copy strobe fires on the same edge as the deferred hit
  assert_defer_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    defer_hit |-> copy_now);
endmodule

// File: tb/sim_vc_slot_table.sv
`timescale 1ns/1ps
module sim_vc_slot_table;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0; logic [3:0] wr_addr = 0; logic [31:0] wr_data = 0;
  logic [3:0] rd_addr = 0; logic [31:0] rd_data;
  logic upd_force = 0, upd_req = 0, act_trig = 0;
  logic [31:0] ctrl_word, status_word;
  logic [5:0] lk_slot = 0; logic [1:0] lk_stream; logic lk_valid; logic [3:0] lk_id;

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;

  logic [31:0] m_pend [8];
  logic [31:0] m_act  [8];
  logic [31:0] m_ctrl;
  bit          m_ack;

  vc_slot_table u0 (.*);

  always #10 clk = ~clk;

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // bench-side restatement of the lookup rule: scan high to low, last match is lowest
  function automatic logic [6:0] ref_lookup(int slot);
    logic [3:0] e; logic [1:0] idx; bit v;
    e = m_act[slot / 8][4*(slot % 8) +: 4];
    v = 0; idx = 0;
    for (int s = 3; s >= 0; s--)
      if (e != 0 && m_ctrl[4 + 4*s +: 4] == e) begin v = 1; idx = 2'(s); end
    v = v && m_ctrl[0];
    return {e, idx, v};
  endfunction

  task automatic tick();
    bit hit;
    hit = upd_req && !m_ack && act_trig;
    @(posedge clk);
    if (upd_force || hit) for (int k = 0; k < 8; k++) m_act[k] = m_pend[k];
    if (!upd_req) m_ack = 0; else if (hit) m_ack = 1;
    if (wr_en) begin
      if (wr_addr < 8) m_pend[wr_addr] = wr_data;
      else if (wr_addr == 8) m_ctrl = wr_data & 32'h000F_FFF1;
    end
    @(negedge clk);
    wr_en = 0; upd_force = 0; act_trig = 0;
  endtask

  task automatic write(int a, logic [31:0] d);
    wr_en = 1; wr_addr = 4'(a); wr_data = d; tick();
  endtask

  task automatic check_all(string req);
    chk(req, "status", status_word, {1'b0, m_ack, 30'b0});
    chk(req, "ctrl", ctrl_word, m_ctrl);
    for (int a = 0; a < 16; a++) begin
      logic [31:0] e;
      rd_addr = 4'(a); #0.05;
      e = (a < 8) ? m_pend[a] : (a == 8) ? m_ctrl : (a == 9) ? {1'b0, m_ack, 30'b0} : 32'h0;
      chk(req, $sformatf("rd[%0d]", a), rd_data, e);
    end
    for (int s = 0; s < 64; s++) begin
      logic [6:0] r;
      lk_slot = 6'(s); #0.05;
      r = ref_lookup(s);
      chk(req, $sformatf("slot%0d", s), {25'b0, lk_id, lk_stream, lk_valid}, {25'b0, r});
    end
  endtask

  initial begin
    while (!finished) begin
      @(posedge clk); cyc++;
      if (cyc > 100000) begin
        errors++; $display("FAIL watchdog: got timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < 8; k++) begin m_pend[k] = 0; m_act[k] = 0; end
    m_ctrl = 0; m_ack = 0;
    repeat (3) @(negedge clk);
    rst_n = 1; @(negedge clk);
    check_all("R1");

    write(8, 32'hFFFF_FFFF); chk("R2", "mask", ctrl_word, 32'h000F_FFF1);
    write(8, 32'h0004_3211); check_all("R2");

    for (int k = 0; k < 8; k++) write(k, 32'h4321_0432 ^ (k << 28));
    check_all("R3");

    act_trig = 1; tick(); check_all("R6");
    upd_force = 1; tick(); check_all("R4");

    write(0, 32'h1111_1111);
    upd_req = 1; tick();
    act_trig = 1; tick(); check_all("R5");
    chk("R5", "ack", status_word[30], 1);

    write(1, 32'h2222_2222);
    act_trig = 1; tick(); check_all("R7");
    upd_req = 0; tick(); check_all("R8");
    chk("R8", "ack", status_word[30], 0);

    upd_req = 1; write(2, 32'h3333_3333);
    upd_force = 1; act_trig = 1; write(3, 32'h4444_4444);
    check_all("R9");
    chk("R9", "ack", status_word[30], 1);
    upd_req = 0; tick();

    write(8, 32'h0001_1331); check_all("R10");
    write(8, 32'h0001_1330); check_all("R10");

    write(12, 32'hDEAD_BEEF); write(9, 32'hFFFF_FFFF); check_all("R11");

    for (int it = 0; it < 250; it++) begin
      wr_en = ($urandom % 3) == 0;
      wr_addr = 4'($urandom % ((($urandom % 4) == 0) ? 16 : 9));
      wr_data = $urandom;
      upd_force = ($urandom % 8) == 0;
      act_trig = ($urandom % 4) == 0;
      if (($urandom % 6) == 0) upd_req = ~upd_req;
      tick();
      if (it % 5 == 0) check_all("R9");
      else chk("R7", "status", status_word, {1'b0, m_ack, 30'b0});
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule